// File: doc/BRIEF.md
# Lockable Identification Page Controller

This block manages the extra identification page of a serial non-volatile memory. A bit-level two-wire front end, which is not part of this block, decodes each write transaction and hands it over as strobes. A start strobe comes with a 4-bit device type code and the word address. Each data byte arrives with its own strobe, and a stop strobe closes the transaction. The controller answers each data byte with an acknowledge or a refusal. It collects accepted bytes for the page and applies them when the stop strobe arrives.

It also runs a one-time lock command. After the lock, the page is permanently read-only. The locked flag models a non-volatile bit: only a dedicated power-on reset clears it. The ordinary transaction reset leaves it untouched. A read port gives random access to the stored page.

Top module: `idpage_ctrl`

## Requirements
- R1: Only a start carrying device type code 1011b selects the block. Data bytes of any other transaction, or bytes with no open transaction, are refused (ack_o = 0) and change no page byte.
- R2: When the lock address bit (bit 10) is 0, the transaction is a page write. While unlocked, every data byte is acknowledged (ack_o = 1). The first byte goes to the slot named by address bits 5:0, and all address bits from 6 upward are ignored.
- R3: Each accepted byte advances the slot pointer by one. The pointer wraps from slot 63 to slot 0, and a later byte that lands on the same slot replaces the earlier one.
- R4: Bytes of a page write reach the page only at the stop strobe. Before the stop, the page is unchanged. A new start before the stop discards the bytes collected so far.
- R5: When address bit 10 is 1, the transaction is a lock command, and its data bytes are acknowledged. The page locks at the stop if exactly one data byte was received and bit 1 of that byte is 1. Every other data bit and address bit is ignored.
- R6: A lock command whose single byte has bit 1 equal to 0 is acknowledged but leaves the page unlocked. So does a lock command carrying two or more data bytes.
- R7: Once locked, every data byte of a page write is refused, and the page content no longer changes.
- R8: The locked flag survives the transaction reset rst_n. Only por_n clears it. por_n also sets every page byte to the erased value 0xFF.
- R9: The acknowledge for a byte appears on ack_o, qualified by ack_vld_o, one clock after the byte strobe is sampled.
- R10: With the default unregistered read option, rd_data_o follows rd_addr_i without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; clears the lock and erases the page |
| rst_n | input | 1 | Transaction reset, active low |
| start_i | input | 1 | Start strobe of a write transaction |
| dev_i | input | 4 | Device type code sent with the start |
| addr_i | input | 16 | Word address sent with the start |
| byte_vld_i | input | 1 | Data byte strobe |
| byte_i | input | 8 | Data byte |
| stop_i | input | 1 | Stop strobe |
| ack_o | output | 1 | 1 = byte acknowledged, 0 = refused |
| ack_vld_o | output | 1 | Qualifies ack_o, one cycle after a byte strobe |
| locked_o | output | 1 | Page is permanently read-only |
| rd_addr_i | input | 6 | Read slot |
| rd_data_o | output | 8 | Page byte at rd_addr_i |

## Verification
The bench builds the block with its default parameters: a 64-byte page, a 16-bit address, the lock selected by bit 10, lock data bit 1, and an unregistered read port. With the full 64-slot pointer, a 66-byte write covers the complete wrap and the overwrite of the first two slots. Setting junk into the upper address bits shows that only bit 10 and the low six bits matter. With the unregistered read, the whole page can be compared against the bench model after each stop without spending clock cycles.

// File: rtl/idp_pkg.sv
package idp_pkg;
   typedef enum logic [1:0] {
      SES_IDLE = 2'd0,
      SES_PAGE = 2'd1,
      SES_LOCK = 2'd2
   } ses_e;

   localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/idp_session.sv
module idp_session
   import idp_pkg::*;
#(
   parameter int unsigned ADDR_W        = 16,
   parameter int unsigned PTR_W         = 6,
   parameter int unsigned LOCK_BIT      = 10,
   parameter int unsigned LOCK_DATA_BIT = 1,
   parameter logic [3:0]  DEV_CODE      = 4'b1011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [3:0]        dev_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              byte_vld_i,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic              stop_i,
   input  logic              locked_i,
   output logic              ack_o,
   output logic              ack_vld_o,
   output logic              st_clr_o,
   output logic              st_we_o,
   output logic [PTR_W-1:0]  st_waddr_o,
   output logic [BYTE_W-1:0] st_wdata_o,
   output logic              commit_o,
   output logic              lock_set_o
);
   ses_e             ses_q;
   logic [PTR_W-1:0] ptr_q;
   logic [1:0]       lk_cnt_q;
   logic             lk_bit_q;
   logic             sel;
   logic             byte_ok;
   logic             take;

   always_comb begin
      sel        = (dev_i == DEV_CODE);
      take       = byte_vld_i && !start_i;
      byte_ok    = (ses_q == SES_LOCK) || ((ses_q == SES_PAGE) && !locked_i);
      st_clr_o   = start_i && sel;
      st_we_o    = take && (ses_q == SES_PAGE) && !locked_i;
      st_waddr_o = ptr_q;
      st_wdata_o = byte_i;
      commit_o   = stop_i && !start_i && (ses_q == SES_PAGE);
      lock_set_o = stop_i && !start_i && (ses_q == SES_LOCK)
                   && (lk_cnt_q == 2'd1) && lk_bit_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ses_q     <= SES_IDLE;
         ptr_q     <= '0;
         lk_cnt_q  <= '0;
         lk_bit_q  <= 1'b0;
         ack_o     <= 1'b0;
         ack_vld_o <= 1'b0;
      end else begin
         ack_vld_o <= take;
         ack_o     <= take && byte_ok;
         if (start_i) begin
            if (!sel)                 ses_q <= SES_IDLE;
            else if (addr_i[LOCK_BIT]) ses_q <= SES_LOCK;
            else                      ses_q <= SES_PAGE;
            ptr_q    <= addr_i[PTR_W-1:0];
            lk_cnt_q <= '0;
            lk_bit_q <= 1'b0;
         end else if (stop_i) begin
            ses_q <= SES_IDLE;
         end else if (byte_vld_i) begin
            if (st_we_o) ptr_q <= ptr_q + 1'b1;
            if (ses_q == SES_LOCK) begin
               if (lk_cnt_q == 2'd0) lk_bit_q <= byte_i[LOCK_DATA_BIT];
               if (lk_cnt_q != 2'd3) lk_cnt_q <= lk_cnt_q + 2'd1;
            end
         end
      end
   end

   AST_FOREIGN_NACK: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld_i && !start_i && ses_q == SES_IDLE) |=> !ack_o); // R1
   AST_ACK_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld_i && !start_i) |=> ack_vld_o); // R9
   AST_LOCKED_NACK: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld_i && !start_i && ses_q == SES_PAGE && locked_i) |=> !ack_o); // R7
   AST_LOCK_BYTE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld_i && !start_i && ses_q == SES_LOCK) |=> ack_o); // R5
endmodule

// File: rtl/idp_stage.sv
module idp_stage
   import idp_pkg::*;
#(
   parameter int unsigned PAGE_BYTES = 64,
   localparam int unsigned PTR_W     = $clog2(PAGE_BYTES)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             clr_i,
   input  logic                             we_i,
   input  logic [PTR_W-1:0]                 waddr_i,
   input  logic [BYTE_W-1:0]                wdata_i,
   output logic [PAGE_BYTES-1:0][BYTE_W-1:0] data_o,
   output logic [PAGE_BYTES-1:0]            mask_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o <= '0;
         mask_o <= '0;
      end else if (clr_i) begin
         mask_o <= '0;
      end else if (we_i) begin
         for (int i = 0; i < PAGE_BYTES; i++) begin
            if (waddr_i == PTR_W'(i)) begin
               data_o[i] <= wdata_i;
               mask_o[i] <= 1'b1;
            end
         end
      end
   end

   AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (mask_o == '0)); // R4
endmodule

// File: rtl/idp_store.sv
module idp_store
   import idp_pkg::*;
#(
   parameter int unsigned PAGE_BYTES = 64,
   parameter logic [7:0]  ERASED     = 8'hFF,
   parameter bit          READ_REG   = 1'b0,
   localparam int unsigned PTR_W     = $clog2(PAGE_BYTES)
) (
   input  logic                             clk,
   input  logic                             por_n,
   input  logic                             commit_i,
   input  logic [PAGE_BYTES-1:0][BYTE_W-1:0] st_data_i,
   input  logic [PAGE_BYTES-1:0]            st_mask_i,
   input  logic                             lock_set_i,
   output logic                             locked_o,
   input  logic [PTR_W-1:0]                 rd_addr_i,
   output logic [BYTE_W-1:0]                rd_data_o
);
   logic [PAGE_BYTES-1:0][BYTE_W-1:0] page_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         page_q   <= {PAGE_BYTES{ERASED}};
         locked_o <= 1'b0;
      end else begin
         if (lock_set_i) locked_o <= 1'b1;
         if (commit_i && !locked_o) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
               if (st_mask_i[i]) page_q[i] <= st_data_i[i];
            end
         end
      end
   end

   generate
      if (READ_REG) begin : g_rd_reg
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) rd_data_o <= ERASED;
            else        rd_data_o <= page_q[rd_addr_i];
         end
      end else begin : g_rd_comb
         assign rd_data_o = page_q[rd_addr_i];
      end
   endgenerate

   AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!por_n)
      locked_o |=> locked_o); // R8
   AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
      locked_o |=> $stable(page_q)); // R7
   AST_COMMIT_ONLY: assert property (@(posedge clk) disable iff (!por_n)
      !commit_i |=> $stable(page_q)); // R4
endmodule

// File: rtl/idpage_ctrl.sv
module idpage_ctrl
   import idp_pkg::*;
#(
   parameter int unsigned PAGE_BYTES    = 64,
   parameter int unsigned ADDR_W        = 16,
   parameter int unsigned LOCK_BIT      = 10,
   parameter int unsigned LOCK_DATA_BIT = 1,
   parameter logic [3:0]  DEV_CODE      = 4'b1011,
   parameter logic [7:0]  ERASED        = 8'hFF,
   parameter bit          READ_REG      = 1'b0,
   localparam int unsigned PTR_W        = $clog2(PAGE_BYTES)
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [3:0]        dev_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              byte_vld_i,
   input  logic [7:0]        byte_i,
   input  logic              stop_i,
   output logic              ack_o,
   output logic              ack_vld_o,
   output logic              locked_o,
   input  logic [PTR_W-1:0]  rd_addr_i,
   output logic [7:0]        rd_data_o
);
   generate
      if ((1 << PTR_W) != PAGE_BYTES) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two");
      end
      if (LOCK_BIT >= ADDR_W || LOCK_BIT < PTR_W) begin : g_bad_lockbit
         $error("LOCK_BIT must lie above the slot bits and inside the address");
      end
      if (LOCK_DATA_BIT >= BYTE_W) begin : g_bad_databit
         $error("LOCK_DATA_BIT must lie inside a byte");
      end
   endgenerate

   logic                              st_clr, st_we, commit, lock_set;
   logic [PTR_W-1:0]                  st_waddr;
   logic [BYTE_W-1:0]                 st_wdata;
   logic [PAGE_BYTES-1:0][BYTE_W-1:0] st_data;
   logic [PAGE_BYTES-1:0]             st_mask;

   idp_session #(
      .ADDR_W(ADDR_W), .PTR_W(PTR_W), .LOCK_BIT(LOCK_BIT),
      .LOCK_DATA_BIT(LOCK_DATA_BIT), .DEV_CODE(DEV_CODE)
   ) u_ses (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .dev_i(dev_i),
      .addr_i(addr_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
      .stop_i(stop_i), .locked_i(locked_o), .ack_o(ack_o),
      .ack_vld_o(ack_vld_o), .st_clr_o(st_clr), .st_we_o(st_we),
      .st_waddr_o(st_waddr), .st_wdata_o(st_wdata), .commit_o(commit),
      .lock_set_o(lock_set)
   );

   idp_stage #(.PAGE_BYTES(PAGE_BYTES)) u_stage (
      .clk(clk), .rst_n(rst_n), .clr_i(st_clr), .we_i(st_we),
      .waddr_i(st_waddr), .wdata_i(st_wdata), .data_o(st_data),
      .mask_o(st_mask)
   );

   idp_store #(
      .PAGE_BYTES(PAGE_BYTES), .ERASED(ERASED), .READ_REG(READ_REG)
   ) u_store (
      .clk(clk), .por_n(por_n), .commit_i(commit), .st_data_i(st_data),
      .st_mask_i(st_mask), .lock_set_i(lock_set), .locked_o(locked_o),
      .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
   );
endmodule

// File: tb/idpage_ctrl_tb.sv
module idpage_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       por_n = 1'b0, rst_n = 1'b0;
   logic       start_i = 1'b0, byte_vld_i = 1'b0, stop_i = 1'b0;
   logic [3:0] dev_i = '0;
   logic [15:0] addr_i = '0;
   logic [7:0] byte_i = '0;
   logic       ack_o, ack_vld_o, locked_o;
   logic [5:0] rd_addr_i = '0;
   logic [7:0] rd_data_o;

   int n_chk = 0, n_fail = 0;
   logic [7:0] exp_pg [64];

   always #2 clk = ~clk;

   idpage_ctrl dut_i (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .start_i(start_i),
      .dev_i(dev_i), .addr_i(addr_i), .byte_vld_i(byte_vld_i),
      .byte_i(byte_i), .stop_i(stop_i), .ack_o(ack_o),
      .ack_vld_o(ack_vld_o), .locked_o(locked_o),
      .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_start(input logic [3:0] code, input logic [15:0] a);
      @(negedge clk);
      start_i = 1'b1; dev_i = code; addr_i = a;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic do_byte(input logic [7:0] d, input bit exp_ack, input string req);
      @(negedge clk);
      byte_vld_i = 1'b1; byte_i = d;
      #1 check(ack_vld_o == 1'b0, "R9", ack_vld_o, 0);
      @(posedge clk); #1;
      check(ack_vld_o == 1'b1, "R9", ack_vld_o, 1);
      check(ack_o == exp_ack, req, ack_o, exp_ack);
      @(negedge clk);
      byte_vld_i = 1'b0;
   endtask

   task automatic do_stop();
      @(negedge clk);
      stop_i = 1'b1;
      @(posedge clk); #1;
      stop_i = 1'b0;
   endtask

   task automatic check_page(input string req);
      for (int i = 0; i < 64; i++) begin
         rd_addr_i = 6'(i);
         #1 check(rd_data_o === exp_pg[i], req, rd_data_o, exp_pg[i]);
      end
   endtask

   task automatic t_reset();
      for (int i = 0; i < 64; i++) exp_pg[i] = 8'hFF;
      #1;
      check(locked_o == 1'b0, "R8", locked_o, 0);
      check(ack_vld_o == 1'b0, "R9", ack_vld_o, 0);
      check_page("R8");
   endtask

   task automatic t_foreign();
      do_start(4'b1010, 16'h0000);
      do_byte(8'h11, 1'b0, "R1");
      do_byte(8'h22, 1'b0, "R1");
      do_stop();
      do_byte(8'h33, 1'b0, "R1");
      check_page("R1");
   endtask

   task automatic t_write();
      do_start(4'b1011, 16'hF83C);
      do_byte(8'hA1, 1'b1, "R2"); exp_pg[6'h3C] = 8'hA1;
      do_byte(8'hA2, 1'b1, "R2"); exp_pg[6'h3D] = 8'hA2;
      do_byte(8'hA3, 1'b1, "R2"); exp_pg[6'h3E] = 8'hA3;
      rd_addr_i = 6'h3C;
      #1 check(rd_data_o == 8'hFF, "R4", rd_data_o, 8'hFF);
      do_stop();
      check_page("R2");
   endtask

   task automatic t_wrap();
      logic [5:0] slot;
      slot = 6'h3E;
      do_start(4'b1011, 16'h0BFE);
      for (int k = 0; k < 66; k++) begin
         do_byte(8'(k + 8'h40), 1'b1, "R3");
         exp_pg[slot] = 8'(k + 8'h40);
         slot = slot + 6'd1;
      end
      do_stop();
      check_page("R3");
   endtask

   task automatic t_restart();
      do_start(4'b1011, 16'h0005);
      do_byte(8'h5A, 1'b1, "R4");
      do_byte(8'h5B, 1'b1, "R4");
      do_start(4'b0110, 16'h0005);
      do_stop();
      check_page("R4");
   endtask

   task automatic t_lock_rejects();
      do_start(4'b1011, 16'h0400);
      do_byte(8'hFD, 1'b1, "R6");
      do_stop();
      #1 check(locked_o == 1'b0, "R6", locked_o, 0);
      do_start(4'b1011, 16'h0400);
      do_byte(8'h02, 1'b1, "R6");
      do_byte(8'h02, 1'b1, "R6");
      do_stop();
      #1 check(locked_o == 1'b0, "R6", locked_o, 0);
   endtask

   task automatic t_lock();
      do_start(4'b1011, 16'hA5C3 | 16'h0400);
      do_byte(8'h02, 1'b1, "R5");
      #1 check(locked_o == 1'b0, "R5", locked_o, 0);
      do_stop();
      #1 check(locked_o == 1'b1, "R5", locked_o, 1);
   endtask

   task automatic t_locked_write();
      do_start(4'b1011, 16'h0000);
      do_byte(8'h99, 1'b0, "R7");
      do_byte(8'h98, 1'b0, "R7");
      do_stop();
      check_page("R7");
   endtask

   task automatic t_resets();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      #1 check(locked_o == 1'b1, "R8", locked_o, 1);
      check_page("R8");
      @(negedge clk); por_n = 1'b0;
      @(negedge clk); por_n = 1'b1;
      for (int i = 0; i < 64; i++) exp_pg[i] = 8'hFF;
      #1 check(locked_o == 1'b0, "R8", locked_o, 0);
      check_page("R8");
   endtask

   task automatic t_read_comb();
      exp_pg[6'h07] = 8'hC7;
      do_start(4'b1011, 16'h0007);
      do_byte(8'hC7, 1'b1, "R2");
      do_stop();
      rd_addr_i = 6'h08;
      #1 check(rd_data_o == 8'hFF, "R10", rd_data_o, 8'hFF);
      rd_addr_i = 6'h07;
      #1 check(rd_data_o == 8'hC7, "R10", rd_data_o, 8'hC7);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      por_n = 1'b1; rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_foreign();
      t_write();
      t_wrap();
      t_restart();
      t_lock_rejects();
      t_lock();
      t_locked_write();
      t_resets();
      t_read_comb();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule